// File: doc/BRIEF.md
# DMA Channel Event Flag Unit

This unit keeps the status and interrupt flags for a single DMA channel. It watches the addresses the channel touches, the channel's transfer counter, its trigger and busy lines, and the progress of a buffered null-write transfer. From these it records five sticky events: an access above the high limit, an access inside the window between the special-register region and the low limit, session completion, the halfway point of the transfer count, and a trigger overrun. Hardware events also produce a one-cycle interrupt request.

The limit check runs on each access as it happens. A bad access is not stopped; it only leaves a flag behind. Software reads the whole state through one 16-bit register and clears flags by writing zeros. A software write that sets a flag changes the register but never produces an interrupt. The 7-bit trigger select field is stored here and sent out to the trigger multiplexer, which lies outside this unit.

Top module: `dma_evt_flags`

## Requirements
- R1: After reset, every register bit reads 0 and `irq_o` is low.
- R2: An access (`acc_valid_i`=1) whose address is above `lim_hi_i` or above the data RAM top (parameter, default 0x7FFF) sets the high flag, bit 7, on the next clock. The access itself is not blocked.
- R3: An access whose address is below `lim_lo_i` and above 0x07FF sets the low flag, bit 6. An access at or below 0x07FF never sets it.
- R4: When `cnt_cur_i` moves down to equal `cnt_init_i`/2 (rounded down, with `cnt_init_i` at least 2), the halfway flag, bit 4, is set. This raises an interrupt only if the enable bit, bit 0, is 1.
- R5: `sess_end_i` with `cnt_cur_i`=0 sets the done flag, bit 5, and raises an interrupt. `sess_end_i` with a nonzero count leaves bit 5 unchanged.
- R6: `trig_i` while `busy_i`=1 sets the overrun flag, bit 3, and raises an interrupt. A trigger while the channel is idle does not.
- R7: Bit 15 is set by `nw_load_i` and cleared by `nw_store_i`. A load wins over a store in the same cycle, and both win over a software write.
- R8: Flags in bits 7:3 are sticky until software writes 0 to them. A hardware set in the same cycle as a software clear leaves the flag at 1.
- R9: A register write updates bits 15:3 and bit 0. Writing 1 to a flag sets it without raising `irq_o`.
- R10: `irq_o` is a one-cycle pulse in the cycle after a hardware event. Address-limit events always pulse it, whatever the value of bit 0.
- R11: Bits 14:8 hold the trigger select, are read/write, and drive `trig_sel_o`. Bits 2:1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Channel access occurring this cycle |
| acc_addr_i | input | AW | Address of the access |
| lim_hi_i | input | AW | High address limit |
| lim_lo_i | input | AW | Low address limit |
| cnt_init_i | input | CW | Transfer count loaded at session start |
| cnt_cur_i | input | CW | Remaining transfer count |
| sess_end_i | input | 1 | Session end strobe |
| trig_i | input | 1 | Channel trigger |
| busy_i | input | 1 | Channel still serving the previous trigger |
| nw_load_i | input | 1 | Null-write buffer captured data |
| nw_store_i | input | 1 | Null-write buffer written to its target |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| trig_sel_o | output | 7 | Trigger select field |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The hardest case to reach is a hardware event and a software write landing on the same edge. This includes a flag being cleared while its event fires, and a set-by-write mixed with a real event, where the interrupt must follow only the event. Directed steps line these collisions up on purpose. A long random phase then drives writes together with addresses near both limits and near the 0x07FF boundary, busy triggers and a falling counter. A behavioural model checks register and interrupt on every cycle. The halfway event needs the counter to approach from above, so the stimulus first sets the count to its start value and then steps it down, with odd and even start values and with the enable both on and off.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned SEL_W    = 7;
  localparam int unsigned SEL_LSB  = 8;
  localparam int unsigned BIT_NWP  = 15;
  localparam int unsigned BIT_HEN  = 0;
  localparam int unsigned FLAG_LSB = 3;
  localparam int unsigned NUM_EVT  = 5;

  // event index; register bit = FLAG_LSB + index
  typedef enum logic [2:0] {
    EV_OVR  = 3'd0,
    EV_HALF = 3'd1,
    EV_DONE = 3'd2,
    EV_LO   = 3'd3,
    EV_HI   = 3'd4
  } evt_e;

  typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/dma_addr_limit.sv
module dma_addr_limit #(
  parameter int unsigned    AW      = 16,
  parameter logic [AW-1:0]  RAM_TOP = 16'h7FFF,
  parameter logic [AW-1:0]  SFR_TOP = 16'h07FF
) (
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [AW-1:0] lim_hi_i,
  input  logic [AW-1:0] lim_lo_i,
  output logic          hi_o,
  output logic          lo_o
);
  logic over_lim, over_ram, under_lim, above_sfr;

  always_comb begin
    over_lim  = acc_addr_i > lim_hi_i;
    over_ram  = acc_addr_i > RAM_TOP;
    under_lim = acc_addr_i < lim_lo_i;
    above_sfr = acc_addr_i > SFR_TOP;
    hi_o      = acc_valid_i && (over_lim || over_ram);
    lo_o      = acc_valid_i && under_lim && above_sfr;
  end
endmodule

// File: rtl/dma_cnt_watch.sv
module dma_cnt_watch #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_init_i,
  input  logic [CW-1:0] cnt_cur_i,
  input  logic          sess_end_i,
  output logic          half_o,
  output logic          done_o
);
  localparam logic [CW-1:0] MIN_INIT = CW'(2);

  logic [CW-1:0] cnt_prev_q;
  logic [CW-1:0] half_mark;
  logic          moved_down;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_prev_q <= '0;
    else         cnt_prev_q <= cnt_cur_i;
  end

  always_comb begin
    half_mark  = cnt_init_i >> 1;
    moved_down = cnt_prev_q > cnt_cur_i;
    half_o     = (cnt_init_i >= MIN_INIT) && moved_down && (cnt_cur_i == half_mark);
    done_o     = sess_end_i && (cnt_cur_i == '0);
  end
endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         sw_we_i,
  input  logic [N-1:0] sw_wdata_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flag_q <= 1'b0;
      else if (evt_i[g])    flag_q <= 1'b1;       // hw set beats sw clear
      else if (sw_we_i)     flag_q <= sw_wdata_i[g];
    end
    assign flags_o[g] = flag_q;
  end
endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen
  import dma_evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  evt_vec_t evt_i,
  input  logic     half_en_i,
  output logic     irq_o
);
  evt_vec_t mask;
  logic     irq_q;

  always_comb begin
    mask          = '1;
    mask[EV_HALF] = half_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(evt_i & mask);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_evt_flags.sv
module dma_evt_flags
  import dma_evt_pkg::*;
#(
  parameter int unsigned   AW      = 16,
  parameter int unsigned   CW      = 16,
  parameter logic [AW-1:0] RAM_TOP = 16'h7FFF,
  parameter logic [AW-1:0] SFR_TOP = 16'h07FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [AW-1:0]     acc_addr_i,
  input  logic [AW-1:0]     lim_hi_i,
  input  logic [AW-1:0]     lim_lo_i,
  input  logic [CW-1:0]     cnt_init_i,
  input  logic [CW-1:0]     cnt_cur_i,
  input  logic              sess_end_i,
  input  logic              trig_i,
  input  logic              busy_i,
  input  logic              nw_load_i,
  input  logic              nw_store_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [SEL_W-1:0]  trig_sel_o,
  output logic              irq_o
);
  localparam int unsigned FLAG_MSB = FLAG_LSB + NUM_EVT - 1;

  logic       hi_evt, lo_evt, half_evt, done_evt, ovr_evt;
  evt_vec_t   evt_vec, flags;
  logic       hw_evt_any;

  logic             nwp_q, hen_q;
  logic [SEL_W-1:0] sel_q;

  dma_addr_limit #(.AW(AW), .RAM_TOP(RAM_TOP), .SFR_TOP(SFR_TOP)) u_lim (
    .acc_valid_i (acc_valid_i),
    .acc_addr_i  (acc_addr_i),
    .lim_hi_i    (lim_hi_i),
    .lim_lo_i    (lim_lo_i),
    .hi_o        (hi_evt),
    .lo_o        (lo_evt)
  );

  dma_cnt_watch #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_init_i (cnt_init_i),
    .cnt_cur_i  (cnt_cur_i),
    .sess_end_i (sess_end_i),
    .half_o     (half_evt),
    .done_o     (done_evt)
  );

  assign ovr_evt = trig_i && busy_i;

  always_comb begin
    evt_vec          = '0;
    evt_vec[EV_HI]   = hi_evt;
    evt_vec[EV_LO]   = lo_evt;
    evt_vec[EV_DONE] = done_evt;
    evt_vec[EV_HALF] = half_evt;
    evt_vec[EV_OVR]  = ovr_evt;
    hw_evt_any       = |evt_vec;
  end

  dma_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_vec),
    .sw_we_i    (reg_wr_i),
    .sw_wdata_i (reg_wdata_i[FLAG_MSB:FLAG_LSB]),
    .flags_o    (flags)
  );

  dma_irq_gen u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_vec),
    .half_en_i (hen_q),
    .irq_o     (irq_o)
  );

  // control fields and null-write pending bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      hen_q <= 1'b0;
    end else if (reg_wr_i) begin
      sel_q <= reg_wdata_i[SEL_LSB +: SEL_W];
      hen_q <= reg_wdata_i[BIT_HEN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         nwp_q <= 1'b0;
    else if (nw_load_i)  nwp_q <= 1'b1;
    else if (nw_store_i) nwp_q <= 1'b0;
    else if (reg_wr_i)   nwp_q <= reg_wdata_i[BIT_NWP];
  end

  always_comb begin
    reg_rdata_o                          = '0;
    reg_rdata_o[BIT_NWP]                 = nwp_q;
    reg_rdata_o[SEL_LSB +: SEL_W]        = sel_q;
    reg_rdata_o[FLAG_MSB:FLAG_LSB]       = flags;
    reg_rdata_o[BIT_HEN]                 = hen_q;
  end

  assign trig_sel_o = sel_q;
endmodule

// File: rtl/dma_evt_flags_chk.sv
module dma_evt_flags_chk #(
  parameter int unsigned   AW      = 16,
  parameter int unsigned   CW      = 16,
  parameter logic [AW-1:0] SFR_TOP = 16'h07FF
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_valid_i,
  input logic [AW-1:0] acc_addr_i,
  input logic [AW-1:0] lim_hi_i,
  input logic [CW-1:0] cnt_cur_i,
  input logic          sess_end_i,
  input logic          trig_i,
  input logic          busy_i,
  input logic          nw_load_i,
  input logic          nw_store_i,
  input logic          reg_wr_i,
  input logic [15:0]   reg_rdata_o,
  input logic          irq_o,
  input logic          hw_evt_any
);
  AST_HI_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_addr_i > lim_hi_i) |=> reg_rdata_o[7]); // R2

  AST_LO_SFR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_addr_i <= SFR_TOP && !reg_wr_i && !reg_rdata_o[6]) |=> !reg_rdata_o[6]); // R3

  AST_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sess_end_i && cnt_cur_i == '0) |=> reg_rdata_o[5]); // R5

  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && busy_i) |=> (reg_rdata_o[3] && irq_o)); // R6

  AST_NW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nw_load_i |=> reg_rdata_o[15]); // R7

  AST_NW_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nw_store_i && !nw_load_i) |=> !reg_rdata_o[15]); // R7

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_wr_i && reg_rdata_o[7]) |=> reg_rdata_o[7]); // R8

  AST_SW_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !hw_evt_any) |=> !irq_o); // R9

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(hw_evt_any)); // R10

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[2:1] == 2'b00); // R11
endmodule

bind dma_evt_flags dma_evt_flags_chk #(.AW(AW), .CW(CW), .SFR_TOP(SFR_TOP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_addr_i  (acc_addr_i),
  .lim_hi_i    (lim_hi_i),
  .cnt_cur_i   (cnt_cur_i),
  .sess_end_i  (sess_end_i),
  .trig_i      (trig_i),
  .busy_i      (busy_i),
  .nw_load_i   (nw_load_i),
  .nw_store_i  (nw_store_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .hw_evt_any  (hw_evt_any)
);

// File: tb/dma_evt_flags_test.sv
`timescale 1ns/1ps
module dma_evt_flags_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = '0, lim_hi = '0, lim_lo = '0;
  logic [15:0] cnt_init = '0, cnt_cur = '0;
  logic        sess_end = 1'b0, trig = 1'b0, busy = 1'b0;
  logic        nw_load = 1'b0, nw_store = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] rdata;
  logic [6:0]  tsel;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_evt_flags uut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .lim_hi_i(lim_hi), .lim_lo_i(lim_lo),
    .cnt_init_i(cnt_init), .cnt_cur_i(cnt_cur),
    .sess_end_i(sess_end), .trig_i(trig), .busy_i(busy),
    .nw_load_i(nw_load), .nw_store_i(nw_store),
    .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .trig_sel_o(tsel), .irq_o(irq)
  );

  // behavioural reference
  logic [15:0] m_reg = '0;
  logic        m_irq = 1'b0;
  int          m_prev = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = '0; m_irq = 1'b0; m_prev = 0;
    end else begin
      bit e_hi, e_lo, e_done, e_half, e_ovr;
      logic [15:0] nxt;
      int a, c, i0;
      a = acc_addr; c = cnt_cur; i0 = cnt_init;
      e_hi   = acc_valid && (a > lim_hi || a > 'h7FFF);
      e_lo   = acc_valid && (a < lim_lo) && (a > 'h07FF);
      e_done = sess_end && (c == 0);
      e_half = (i0 >= 2) && (c == i0 / 2) && (m_prev > c);
      e_ovr  = trig && busy;
      nxt = m_reg;
      if (reg_wr) nxt = reg_wdata & 16'hFFF9;
      if (nw_load) nxt[15] = 1'b1;
      else if (nw_store) nxt[15] = 1'b0;
      else nxt[15] = reg_wr ? reg_wdata[15] : m_reg[15];
      if (e_hi)   nxt[7] = 1'b1;
      if (e_lo)   nxt[6] = 1'b1;
      if (e_done) nxt[5] = 1'b1;
      if (e_half) nxt[4] = 1'b1;
      if (e_ovr)  nxt[3] = 1'b1;
      m_irq  = e_hi | e_lo | e_done | e_ovr | (e_half & m_reg[0]);
      m_reg  = nxt;
      m_prev = c;
    end
  end

  function automatic string tag_of(int b);
    case (b)
      15: return "R7";
      7:  return "R2";
      6:  return "R3";
      5:  return "R5";
      4:  return "R4";
      3:  return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (rdata !== m_reg) begin
      errors++;
      for (int b = 0; b < 16; b++)
        if (rdata[b] !== m_reg[b])
          $display("FAIL %s reg bit %0d actual %h expected %h", tag_of(b), b, rdata, m_reg);
    end
    checks++;
    if (irq !== m_irq) begin
      errors++;
      $display("FAIL R10 irq actual %b expected %b", irq, m_irq);
    end
    checks++;
    if (tsel !== m_reg[14:8]) begin
      errors++;
      $display("FAIL R11 trig_sel actual %h expected %h", tsel, m_reg[14:8]);
    end
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    acc_valid = 0; sess_end = 0; trig = 0; busy = 0;
    nw_load = 0; nw_store = 0; reg_wr = 0;
  endtask

  task automatic wr(logic [15:0] d);
    reg_wr = 1; reg_wdata = d; step(); reg_wr = 0;
  endtask

  task automatic access(logic [15:0] a);
    acc_valid = 1; acc_addr = a; step(); acc_valid = 0;
  endtask

  task automatic count_down(int init, bit hen);
    wr(hen ? 16'h0001 : 16'h0000);
    cnt_init = 16'(init); cnt_cur = 16'(init); step();
    for (int c = init - 1; c >= 0; c--) begin
      cnt_cur = 16'(c); step();
      if (c == init / 2) begin
        chk(rdata[4] === 1'b1, "R4 halfway flag", rdata[4], 1);
        chk(irq === hen, "R4 halfway irq gating", irq, hen);
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rdata === 16'h0000, "R1 reset reg", rdata, 0);
    chk(irq === 1'b0, "R1 reset irq", irq, 0);

    // R9: software sets flags, no interrupt
    wr(16'hFFFF);
    chk(rdata === 16'hFFF9, "R9 sw write value", rdata, 16'hFFF9);
    chk(irq === 1'b0, "R9 sw set no irq", irq, 0);
    chk(tsel === 7'h7F, "R11 trig select out", tsel, 7'h7F);
    wr(16'h0000);

    // R2/R3 address limits
    lim_hi = 16'h6000; lim_lo = 16'h1000;
    access(16'h5000);
    chk(rdata[7:6] === 2'b00, "R2 in-window access", rdata[7:6], 0);
    access(16'h6001);
    chk(rdata[7] === 1'b1 && irq === 1'b1, "R2 above high limit", {rdata[7], irq}, 3);
    wr(16'h0000);
    access(16'h07FF);
    chk(rdata[6] === 1'b0, "R3 sfr edge ignored", rdata[6], 0);
    access(16'h0100);
    chk(rdata[6] === 1'b0, "R3 sfr region ignored", rdata[6], 0);
    access(16'h0800);
    chk(rdata[6] === 1'b1, "R3 low window", rdata[6], 1);
    wr(16'h0000);
    lim_hi = 16'hFFFF;
    access(16'h8000);
    chk(rdata[7] === 1'b1, "R2 above ram top", rdata[7], 1);
    wr(16'h0000);
    acc_valid = 0; acc_addr = 16'hF000; step();
    chk(rdata[7] === 1'b0, "R2 no strobe no flag", rdata[7], 0);
    // R10: address event pulses with halfway enable off
    access(16'h9000);
    chk(irq === 1'b1, "R10 addr irq hen=0", irq, 1);
    step();
    chk(irq === 1'b0, "R10 single pulse", irq, 0);
    wr(16'h0000);

    // R4 halfway
    count_down(10, 1);
    count_down(10, 0);
    count_down(9, 1);
    wr(16'h0000);

    // R5 done
    cnt_cur = 3; sess_end = 1; step(); sess_end = 0;
    chk(rdata[5] === 1'b0, "R5 end without completion", rdata[5], 0);
    cnt_cur = 0; sess_end = 1; step(); sess_end = 0;
    chk(rdata[5] === 1'b1 && irq === 1'b1, "R5 completion", {rdata[5], irq}, 3);

    // R6 overrun
    trig = 1; busy = 0; step(); trig = 0;
    chk(rdata[3] === 1'b0, "R6 idle trigger", rdata[3], 0);
    trig = 1; busy = 1; step(); trig = 0; busy = 0;
    chk(rdata[3] === 1'b1, "R6 busy trigger", rdata[3], 1);

    // R7 null-write pending
    nw_load = 1; step(); nw_load = 0;
    chk(rdata[15] === 1'b1, "R7 pending set", rdata[15], 1);
    nw_store = 1; step(); nw_store = 0;
    chk(rdata[15] === 1'b0, "R7 pending cleared", rdata[15], 0);

    // R8 hw set vs sw clear same cycle
    wr(16'h0000);
    trig = 1; busy = 1; reg_wr = 1; reg_wdata = 16'h0000; step(); idle();
    chk(rdata[3] === 1'b1, "R8 hw set beats sw clear", rdata[3], 1);
    step(); step();
    chk(rdata[3] === 1'b1, "R8 sticky", rdata[3], 1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom;
      acc_valid = r[0];
      case (r[3:1])
        0: acc_addr = 16'h07F0 + 16'($urandom_range(0, 31));
        1: acc_addr = lim_lo - 16'($urandom_range(0, 3)) + 16'd1;
        2: acc_addr = lim_hi + 16'($urandom_range(0, 3)) - 16'd1;
        3: acc_addr = 16'h7FFE + 16'($urandom_range(0, 3));
        default: acc_addr = 16'($urandom);
      endcase
      if (r[7:4] == 0) begin
        lim_hi = 16'($urandom_range(16'h2000, 16'h9000));
        lim_lo = 16'($urandom_range(16'h0400, 16'h1800));
      end
      trig = r[8]; busy = r[9];
      sess_end = (r[12:10] == 0);
      nw_load = (r[15:13] == 0); nw_store = (r[18:16] == 0);
      reg_wr = (r[21:19] == 0); reg_wdata = 16'($urandom);
      if (r[25:22] == 0) begin
        cnt_init = 16'($urandom_range(0, 40)); cnt_cur = cnt_init;
      end else if (cnt_cur != 0 && r[26]) cnt_cur = cnt_cur - 16'd1;
      step();
    end
    idle(); step();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule